// File: doc/BRIEF.md
# Asynchronous byte-lane SRAM controller

This block sits between a synchronous host port and an external asynchronous static RAM. The RAM has a 19-bit word address and a 24-bit data bus split into three 8-bit lanes. Each lane has its own active-low select. The RAM also has active-low write-enable and output-enable strobes. The host offers one request at a time with a valid/ready handshake: a read/write flag, an address, write data and a 3-bit lane mask. Reads come back on a data port that carries a one-cycle valid strobe.

The controller turns each request into a cycle-counted strobe sequence. Every analog minimum (write pulse, data setup, write cycle, access time, output-enable access, read cycle, power-up wait) is a parameter in picoseconds, converted to clock cycles by rounding up against a clock-period parameter. The data bus is split into an output value, an output-enable and an input value; the pad tristate is built outside this block. The controller drives the bus only inside a window it fully controls. It puts one dead cycle between a read and a following write, so the RAM and the controller never drive at once.

Top module: `sram_byte_ctl`

## Requirements
- R1: Lane i (i = 0, 1, 2) covers data bits 8i+7:8i. Host mask bit i set pulls mem_cs_n[i] low for the access. A select is low only while a write or read strobe is active; with both mem_we_n and mem_oe_n high, all selects are high.
- R2: A write puts only the masked lanes into the addressed word. Address and selects are stable for the whole low phase of mem_we_n. Driven data is present at least the data-setup time before mem_we_n rises.
- R3: mem_oe_n stays high for the whole of a write. A read holds mem_we_n high and mem_oe_n low.
- R4: The controller drives the data bus (mem_dq_oe = 1) from the cycle after mem_we_n falls until the cycle after it rises. It never drives while mem_oe_n is low.
- R5: mem_we_n stays low for N_WE = max(ceil(T_WP/T_CLK), ceil(T_DS/T_CLK)+1) cycles, which is 3 at 4 ns. mem_oe_n stays low for N_RD = max(ceil(T_AA/T_CLK), ceil(T_DOE/T_CLK), ceil(T_RC/T_CLK)-1) cycles, which is 3 at 4 ns. Read data is sampled at the clock edge that ends that window.
- R6: A read returns the selected lanes of the word and zeros in unselected lanes. rsp_valid is high for exactly one cycle, beginning at the edge that samples the data.
- R7: When a write follows a read, one dead cycle with all strobes high is inserted. mem_we_n therefore falls two cycles after the read's rsp_valid rises.
- R8: After reset, req_ready stays low and all selects stay high for ceil(T_PWR/T_CLK) cycles. req_ready then rises and stays available.
- R9: A request with mask 000 is accepted and drives no strobe. A write with that mask leaves memory unchanged. A read with that mask returns rsp_valid with all-zero data in the cycle after acceptance.
- R10: During reset: req_ready = 0, rsp_valid = 0, mem_cs_n = 111, mem_we_n = 1, mem_oe_n = 1, mem_dq_oe = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 24 | Write data |
| req_lanes | input | 3 | Lane mask, bit i enables bits 8i+7:8i |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 24 | Read data, unselected lanes zero |
| mem_addr | output | 19 | RAM address |
| mem_cs_n | output | 3 | Per-lane select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 24 | Data to drive onto the RAM bus |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 24 | Data seen on the RAM bus |

## Verification
The main function is exercised with full-mask, single-lane, two-lane and empty-mask accesses, at a low address and at the top address. Single-lane writes onto a known word show whether other lanes are left alone. Two-lane reads show whether unselected lanes are zeroed rather than passed through. The bench memory returns a garbage pattern until access time has elapsed and in unselected lanes, so a short read window or a missing mask shows up as wrong data. A read followed at once by a write separates a design with the dead turnaround cycle from one without it.

// File: rtl/sram_byte_pkg.sv
package sram_byte_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_WR,
    ST_WHOLD,
    ST_RD
  } ctl_state_t;

  // Whole cycles needed to cover a time given in picoseconds.
  function automatic int cyc_ceil(input int time_ps, input int clk_ps);
    return (time_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_byte_pwrup.sv
module sram_byte_pwrup #(
  parameter int LIMIT = 250000,
  localparam int W    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  output logic done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
      if (cnt == W'(LIMIT - 1)) done <= 1'b1;
    end
  end

  AST_PWR_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done); // R8

endmodule

// File: rtl/sram_byte_timer.sv
module sram_byte_timer #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/sram_byte_lanes.sv
module sram_byte_lanes #(
  parameter int LANES  = 3,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic [LANES-1:0] lanes,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    dq_sel
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign dq_sel[i*LANE_W +: LANE_W] = lanes[i] ? dq_in[i*LANE_W +: LANE_W] : '0;
  end

endmodule

// File: rtl/sram_byte_ctl.sv
module sram_byte_ctl
  import sram_byte_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int LANES     = 3,
  parameter int LANE_W    = 8,
  parameter int CLK_PS    = 4000,
  parameter int T_WP_PS   = 7000,
  parameter int T_DS_PS   = 5500,
  parameter int T_WC_PS   = 10000,
  parameter int T_AA_PS   = 10000,
  parameter int T_DOE_PS  = 5000,
  parameter int T_RC_PS   = 10000,
  parameter int T_PWR_PS  = 1000000000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [LANES*LANE_W-1:0]   req_wdata,
  input  logic [LANES-1:0]          req_lanes,
  output logic                      rsp_valid,
  output logic [LANES*LANE_W-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [LANES-1:0]          mem_cs_n,
  output logic                      mem_we_n,
  output logic                      mem_oe_n,
  output logic [LANES*LANE_W-1:0]   mem_dq_out,
  output logic                      mem_dq_oe,
  input  logic [LANES*LANE_W-1:0]   mem_dq_in
);

  localparam int DW    = LANES * LANE_W;
  localparam int N_WE  = imax(cyc_ceil(T_WP_PS, CLK_PS), cyc_ceil(T_DS_PS, CLK_PS) + 1);
  localparam int N_REC = imax(1, cyc_ceil(T_WC_PS, CLK_PS) - N_WE - 1);
  localparam int N_RD  = imax(imax(cyc_ceil(T_AA_PS, CLK_PS), cyc_ceil(T_DOE_PS, CLK_PS)),
                              cyc_ceil(T_RC_PS, CLK_PS) - 1);
  localparam int N_PWR = imax(1, cyc_ceil(T_PWR_PS, CLK_PS));
  localparam int TW    = $clog2(imax(imax(N_WE, N_REC), N_RD) + 1);
  localparam int CW    = TW + 1;

  ctl_state_t        state;
  logic [ADDR_W-1:0] lat_addr;
  logic [DW-1:0]     lat_wdata;
  logic [LANES-1:0]  lat_lanes;
  logic              last_rd;
  logic              pwr_done;
  logic              accept;
  logic              tmr_load;
  logic [TW-1:0]     tmr_val;
  logic              tmr_done;
  logic [DW-1:0]     rd_masked;

  sram_byte_pwrup #(.LIMIT(N_PWR)) u_pwrup (
    .clk  (clk),
    .rst  (rst),
    .done (pwr_done)
  );

  sram_byte_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_byte_lanes #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .lanes  (lat_lanes),
    .dq_in  (mem_dq_in),
    .dq_sel (rd_masked)
  );

  assign req_ready = (state == ST_IDLE) && pwr_done;
  assign accept    = req_valid && req_ready;

  // Phase timer loads: each phase lasts (load value + 1) cycles.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE: if (accept && (|req_lanes)) begin
        if (!req_write) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(N_RD - 1);
        end else if (!last_rd) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(N_WE - 1);
        end
      end
      ST_TURN: begin
        tmr_load = 1'b1;
        tmr_val  = TW'(N_WE - 1);
      end
      ST_WR: if (tmr_done) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(N_REC - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      lat_addr   <= '0;
      lat_wdata  <= '0;
      lat_lanes  <= '0;
      last_rd    <= 1'b0;
      mem_addr   <= '0;
      mem_cs_n   <= '1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          lat_addr  <= req_addr;
          lat_wdata <= req_wdata;
          lat_lanes <= req_lanes;
          if (req_lanes == '0) begin
            if (!req_write) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= '0;
            end
          end else if (req_write) begin
            if (last_rd) begin
              state <= ST_TURN;
            end else begin
              state      <= ST_WR;
              mem_addr   <= req_addr;
              mem_cs_n   <= ~req_lanes;
              mem_we_n   <= 1'b0;
              mem_dq_out <= req_wdata;
            end
          end else begin
            state    <= ST_RD;
            mem_addr <= req_addr;
            mem_cs_n <= ~req_lanes;
            mem_oe_n <= 1'b0;
          end
        end
        ST_TURN: begin
          state      <= ST_WR;
          last_rd    <= 1'b0;
          mem_addr   <= lat_addr;
          mem_cs_n   <= ~lat_lanes;
          mem_we_n   <= 1'b0;
          mem_dq_out <= lat_wdata;
        end
        ST_WR: begin
          mem_dq_oe <= 1'b1;
          if (tmr_done) begin
            state    <= ST_WHOLD;
            mem_we_n <= 1'b1;
            mem_cs_n <= '1;
          end
        end
        ST_WHOLD: if (tmr_done) begin
          state     <= ST_IDLE;
          mem_dq_oe <= 1'b0;
        end
        ST_RD: if (tmr_done) begin
          state     <= ST_IDLE;
          rsp_valid <= 1'b1;
          rsp_rdata <= rd_masked;
          mem_cs_n  <= '1;
          mem_oe_n  <= 1'b1;
          last_rd   <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checker state: length of the current low phase of the write strobe.
  logic [CW-1:0] we_low_cnt;
  always_ff @(posedge clk) begin
    if (rst)                   we_low_cnt <= '0;
    else if (mem_we_n)         we_low_cnt <= '0;
    else if (we_low_cnt != '1) we_low_cnt <= we_low_cnt + 1'b1;
  end

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n); // R3
  AST_DQ_NOT_IN_READ: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n); // R4
  AST_DQ_AFTER_WE: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (!mem_we_n && $past(!mem_we_n))); // R4
  AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_low_cnt >= CW'(N_WE))); // R5
  AST_LANES_IDLE: assert property (@(posedge clk) disable iff (rst)
    (mem_we_n && mem_oe_n) |-> (&mem_cs_n)); // R1
  AST_NO_ACCESS_PWRUP: assert property (@(posedge clk) disable iff (rst)
    !pwr_done |-> ((&mem_cs_n) && !req_ready)); // R8

endmodule

// File: tb/sram_byte_ctl_test.sv
`timescale 1ns/1ps
module sram_byte_ctl_test;

  localparam int PWR_CYC = 100;   // 400 ns / 4 ns
  localparam int EXP_WE  = 3;     // max(ceil(7/4), ceil(5.5/4)+1)
  localparam int EXP_RD  = 3;     // max(ceil(10/4), ceil(5/4), ceil(10/4)-1)

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [23:0] req_wdata = '0;
  logic [2:0]  req_lanes = '0;
  logic        rsp_valid;
  logic [23:0] rsp_rdata;
  logic [18:0] mem_addr;
  logic [2:0]  mem_cs_n;
  logic        mem_we_n;
  logic        mem_oe_n;
  logic [23:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [23:0] mem_dq_in = '0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sram_byte_ctl #(.T_PWR_PS(400000)) uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_lanes(req_lanes),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // ---------------- behavioural RAM with timing and contention checks ----
  logic [23:0] mem_model [int];
  realtime t_addr = -100.0;
  realtime t_oe   = -100.0;
  always @(mem_addr)         t_addr = $realtime;
  always @(negedge mem_oe_n) t_oe   = $realtime;

  function automatic logic [23:0] rd_word(input logic [18:0] a);
    return mem_model.exists(int'(a)) ? mem_model[int'(a)] : 24'h0;
  endfunction

  logic        prev_we = 1'b1, prev_oe = 1'b1, prev_dq = 1'b0;
  int          we_run = 0, dq_run = 0, oe_run = 0;
  int          last_we_len = 0, last_oe_len = 0;
  int          we_fall_cyc = 0, we_rise_cyc = 0, dq_rise_cyc = 0, dq_fall_cyc = 0;
  int          rsp_cnt = 0, rsp_cyc = 0, act_cnt = 0;
  int          tviol = 0, oe_viol = 0, cont = 0;
  logic [23:0] rsp_data = '0, pend_data = '0;
  logic [18:0] wr_addr0 = '0;
  logic [2:0]  pend_cs = '1, last_wr_cs = '1;

  always @(negedge clk) begin
    if (!rst) begin
      logic        drives;
      logic        valid;
      logic [23:0] w;
      realtime     ts;
      if (prev_we && !mem_we_n) begin
        we_fall_cyc = cyc; wr_addr0 = mem_addr; we_run = 0; dq_run = 0;
      end
      if (!mem_we_n) begin
        we_run++;
        if (mem_dq_oe) begin dq_run++; pend_data = mem_dq_out; end
        pend_cs = mem_cs_n; last_wr_cs = mem_cs_n;
        if (mem_addr != wr_addr0) tviol++;
        if (!mem_oe_n) oe_viol++;
      end
      if (!prev_we && mem_we_n) begin
        we_rise_cyc = cyc; last_we_len = we_run;
        if (we_run * 4.0 < 7.0 || dq_run * 4.0 < 5.5) tviol++;
        w = rd_word(wr_addr0);
        for (int i = 0; i < 3; i++)
          if (!pend_cs[i]) w[i*8 +: 8] = pend_data[i*8 +: 8];
        mem_model[int'(wr_addr0)] = w;
      end
      if (!prev_dq && mem_dq_oe) dq_rise_cyc = cyc;
      if (prev_dq && !mem_dq_oe) dq_fall_cyc = cyc;
      if (prev_oe && !mem_oe_n) oe_run = 0;
      if (!mem_oe_n) oe_run++;
      if (!prev_oe && mem_oe_n) last_oe_len = oe_run;
      if (rsp_valid) begin rsp_cnt++; rsp_data = rsp_rdata; rsp_cyc = cyc; end
      if (~&mem_cs_n) act_cnt++;
      drives = (~&mem_cs_n) && !mem_oe_n && mem_we_n;
      if (drives && mem_dq_oe) cont++;
      // Value seen by the controller at the next rising edge.
      ts    = $realtime + 2.0;
      valid = (ts - t_addr >= 9.999) && (ts - t_oe >= 4.999);
      w     = rd_word(mem_addr);
      for (int i = 0; i < 3; i++)
        mem_dq_in[i*8 +: 8] = !drives ? 8'h3C : (mem_cs_n[i] ? 8'hA5 : (valid ? w[i*8 +: 8] : 8'h5A));
      prev_we = mem_we_n; prev_oe = mem_oe_n; prev_dq = mem_dq_oe;
    end
  end

  // ---------------- helpers ---------------------------------------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at a falling edge after acceptance.
  task automatic send(input logic w, input logic [18:0] a, input logic [23:0] d, input logic [2:0] m);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_lanes = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp(input int n0);
    for (int g = 0; g < 50 && rsp_cnt == n0; g++) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // {write, addr[18:0], wdata[23:0], lanes[2:0], expected read[23:0]}
  localparam logic [70:0] VEC [13] = '{
    {1'b1, 19'h00010, 24'h112233, 3'b111, 24'h000000},
    {1'b0, 19'h00010, 24'h000000, 3'b111, 24'h112233},
    {1'b1, 19'h00010, 24'hAABBCC, 3'b010, 24'h000000},
    {1'b0, 19'h00010, 24'h000000, 3'b111, 24'h11BB33},
    {1'b0, 19'h00010, 24'h000000, 3'b101, 24'h110033},
    {1'b1, 19'h7FFFF, 24'hFEDCBA, 3'b111, 24'h000000},
    {1'b0, 19'h7FFFF, 24'h000000, 3'b001, 24'h0000BA},
    {1'b1, 19'h00020, 24'h445566, 3'b100, 24'h000000},
    {1'b0, 19'h00020, 24'h000000, 3'b111, 24'h440000},
    {1'b0, 19'h7FFFF, 24'h000000, 3'b110, 24'hFEDC00},
    {1'b1, 19'h00010, 24'h000000, 3'b000, 24'h000000},
    {1'b0, 19'h00010, 24'h000000, 3'b111, 24'h11BB33},
    {1'b0, 19'h00010, 24'h000000, 3'b000, 24'h000000}
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    // R10: reset state
    repeat (4) @(negedge clk);
    chk("R10 ready", {31'd0, req_ready}, 32'd0);
    chk("R10 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R10 strobes", {28'd0, mem_cs_n, mem_we_n}, {28'd0, 3'b111, 1'b1});
    chk("R10 oe/dq_oe", {30'd0, mem_oe_n, mem_dq_oe}, {30'd0, 1'b1, 1'b0});
    rst = 1'b0;

    // R8: power-up hold-off
    repeat (PWR_CYC - 1) @(negedge clk);
    chk("R8 ready before wait ends", {31'd0, req_ready}, 32'd0);
    chk("R8 no select during wait", act_cnt, 0);
    @(negedge clk);
    chk("R8 ready after wait", {31'd0, req_ready}, 32'd1);

    // Vector table: R1, R2, R6, R9
    for (int k = 0; k < 13; k++) begin
      logic        vw;
      logic [18:0] va;
      logic [23:0] vd;
      logic [2:0]  vm;
      logic [23:0] ve;
      int          n0, a0, f0;
      {vw, va, vd, vm, ve} = VEC[k];
      n0 = rsp_cnt; a0 = act_cnt; f0 = we_fall_cyc;
      send(vw, va, vd, vm);
      if (!vw) begin
        wait_rsp(n0);
        chk(vm == 3'b000 ? "R9 empty-mask read data" : "R6 read data", rsp_data, ve);
      end else begin
        repeat (6) @(negedge clk);
        if (vm != 3'b000) begin
          chk("R1 lane selects on write", {29'd0, last_wr_cs}, {29'd0, ~vm});
          chk("R2 write timing/address", tviol, 0);
        end else begin
          chk("R9 empty-mask write no strobe", we_fall_cyc - f0, 0);
        end
      end
      if (vm == 3'b000) chk("R9 no select activity", act_cnt - a0, 0);
    end

    // R5 / R4: strobe lengths and drive window of the last real write and read
    chk("R5 we low cycles", last_we_len, EXP_WE);
    chk("R5 oe low cycles", last_oe_len, EXP_RD);
    chk("R4 drive starts after we falls", dq_rise_cyc - we_fall_cyc, 1);
    chk("R4 drive ends after we rises", dq_fall_cyc - we_rise_cyc, 1);

    // R7: write right behind a read gets a dead cycle
    begin
      int n0;
      n0 = rsp_cnt;
      send(1'b0, 19'h00010, 24'h0, 3'b111);
      send(1'b1, 19'h00030, 24'h0F0F0F, 3'b001);
      wait_rsp(n0);
      repeat (8) @(negedge clk);
      chk("R7 read-to-write turnaround", we_fall_cyc - rsp_cyc, 2);
      n0 = rsp_cnt;
      send(1'b0, 19'h00030, 24'h0, 3'b111);
      wait_rsp(n0);
      chk("R2 single-lane write after read", rsp_data, 24'h00000F);
    end

    repeat (4) @(negedge clk);
    chk("R3 oe high during writes", oe_viol, 0);
    chk("R4 no bus contention", cont, 0);
    chk("R2 no timing violation", tviol, 0);
    finish_up();
  end

endmodule